// File: doc/BRIEF.md
# Pipelined Shared-Bus Transaction Controller

This controller arbitrates a shared on-chip bus among a parameterised number of masters and sequences each transfer through three phases: request/grant, address and data. A master raises its request together with the transfer address, direction, size and block length. The controller grants it in that same cycle if the address stage is free or is being vacated. The next cycle is the transfer's address phase, and the cycle after that begins its data phase. Phases of consecutive transfers overlap, so single transfers complete at one per cycle.

A block transfer occupies the data phase for 2, 4 or 8 beats. The controller counts these beats and flags the final one. A transfer granted behind a block stays in its address phase until the block's final beat. The controller checks address alignment for the transfer size. A misaligned transfer never reaches the bus. Its master instead sees a one-cycle error pulse in the cycle that would have ended its address phase. Slaves are taken to be always ready.

Top module: `shared_bus_ctrl`

## Requirements
- R1: While the address stage is empty or advancing, a requesting master receives `gnt` in the same cycle as its request, and master details are captured at that grant. No grant is issued while `rst_n` is low.
- R2: Priority is fixed, with index 0 the highest. At most one grant is issued per cycle, and a master that loses keeps waiting until it is granted.
- R3: In the cycle after its grant, an accepted transfer drives its master's `addr_ph` bit, and `bus_addr` carries the captured address.
- R4: The data phase starts in the cycle after the address phase ends. Its master's `data_ph` bit is set, and `bus_wr` shows the captured direction (1 = write).
- R5: A single transfer has exactly one data beat, and `last_beat` is set in that beat. A block has 2, 4 or 8 beats for `blen` codes 0, 1 or 2, and `last_beat` is set only in the final beat.
- R6: While a block is in a data beat other than its final beat, the next transfer's address phase is held, and no new grant is issued. That address phase ends in the cycle of the block's final beat.
- R7: Single transfers granted in consecutive cycles, including two from the same master, keep one address phase and one data beat per cycle.
- R8: Size codes are 0 byte, 1 half-word, 2 word and 3 block. A byte transfer is always aligned. A half-word transfer needs address bit 0 clear, and a word transfer needs address bits 1:0 clear.
- R9: A block transfer needs its address aligned to its total size: 8, 16 or 32 bytes. A block with `blen` code 3 counts as misaligned.
- R10: A misaligned transfer produces no `addr_ph` and no `data_ph`. Its master's `err` bit pulses for one cycle, in the cycle its address phase would have ended, and that may be delayed by a block stall.
- R11: Reset is synchronous and active-low. At the first clock edge with `rst_n` low, all phases are cleared, even in the middle of a block transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NM | Per-master request |
| addr | input | NM*AW | Per-master transfer address, master i at bits [i*AW +: AW] |
| wr | input | NM | Per-master direction, 1 = write |
| size | input | 2*NM | Per-master size code (0 byte, 1 half, 2 word, 3 block) |
| blen | input | 2*NM | Per-master block length code (0: 2, 1: 4, 2: 8 beats) |
| gnt | output | NM | Grant, one-hot or zero |
| addr_ph | output | NM | Address phase of the indicated master |
| data_ph | output | NM | Data beat of the indicated master |
| last_beat | output | 1 | Current data beat is the transfer's final beat |
| err | output | NM | One-cycle misalignment error to the indicated master |
| bus_addr | output | AW | Address presented during the address phase |
| bus_wr | output | 1 | Direction of the current data beat |

## Verification
The hardest situation to reach is a misaligned transfer waiting in the address stage behind a multi-beat block. Its error pulse must be delayed to the block's final beat, with no address phase shown during the wait. The bench reaches it with a block request followed one cycle later by a misaligned word request from another master. A second stalled case has a third master request during the stall. Its grant must wait for the block's final beat, and then it must follow the stalled transfer without a gap.

// File: rtl/shared_bus_ctrl.sv
module shared_bus_ctrl #(
  parameter int NM = 3,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NM-1:0]   req,
  input  logic [NM*AW-1:0] addr,
  input  logic [NM-1:0]   wr,
  input  logic [2*NM-1:0] size,
  input  logic [2*NM-1:0] blen,
  output logic [NM-1:0]   gnt,
  output logic [NM-1:0]   addr_ph,
  output logic [NM-1:0]   data_ph,
  output logic            last_beat,
  output logic [NM-1:0]   err,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_wr
);
  localparam int MW = (NM > 1) ? $clog2(NM) : 1;
  localparam int CW = 3;

  logic          a_v, a_wr, a_bad;
  logic [MW-1:0] a_m;
  logic [AW-1:0] a_addr;
  logic [CW-1:0] a_beats;
  logic          d_v, d_wr;
  logic [MW-1:0] d_m;
  logic [CW-1:0] d_cnt;

  logic          d_more, a_adv, a_free, found;
  logic [MW-1:0] sel;
  logic [AW-1:0] s_addr;
  logic [1:0]    s_size, s_blen;
  logic          s_bad;
  logic [CW-1:0] s_beats;

  assign d_more = d_v && (d_cnt != '0);
  assign a_adv  = a_v && !d_more;
  assign a_free = !a_v || a_adv;

  always_comb begin
    gnt   = '0;
    sel   = '0;
    found = 1'b0;
    if (rst_n && a_free)
      for (int i = 0; i < NM; i++)
        if (req[i] && !found) begin
          gnt[i] = 1'b1;
          sel    = MW'(i);
          found  = 1'b1;
        end
  end

  assign s_addr = addr[sel*AW +: AW];
  assign s_size = size[sel*2 +: 2];
  assign s_blen = blen[sel*2 +: 2];

  always_comb begin
    s_beats = '0;
    case (s_size)
      2'd0: s_bad = 1'b0;
      2'd1: s_bad = s_addr[0];
      2'd2: s_bad = |s_addr[1:0];
      default: begin
        case (s_blen)
          2'd0:    begin s_bad = |s_addr[2:0]; s_beats = 3'd1; end
          2'd1:    begin s_bad = |s_addr[3:0]; s_beats = 3'd3; end
          2'd2:    begin s_bad = |s_addr[4:0]; s_beats = 3'd7; end
          default: s_bad = 1'b1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_v <= 1'b0; a_wr <= 1'b0; a_bad <= 1'b0; a_m <= '0;
      a_addr <= '0; a_beats <= '0;
    end else begin
      if (a_free) a_v <= found;
      if (found) begin
        a_m     <= sel;
        a_addr  <= s_addr;
        a_wr    <= wr[sel];
        a_bad   <= s_bad;
        a_beats <= s_beats;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_v <= 1'b0; d_wr <= 1'b0; d_m <= '0; d_cnt <= '0;
    end else if (a_adv && !a_bad) begin
      d_v   <= 1'b1;
      d_m   <= a_m;
      d_wr  <= a_wr;
      d_cnt <= a_beats;
    end else if (d_v) begin
      if (d_cnt == '0) d_v <= 1'b0;
      else d_cnt <= d_cnt - 1'b1;
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_out
    assign addr_ph[i] = a_v && !a_bad && (a_m == MW'(i));
    assign data_ph[i] = d_v && (d_m == MW'(i));
    assign err[i]     = a_adv && a_bad && (a_m == MW'(i));
  end

  assign last_beat = d_v && (d_cnt == '0);
  assign bus_addr  = a_addr;
  assign bus_wr    = d_wr;

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_gnt_then_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> (|addr_ph || |err || d_more));
  assert_addr_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|addr_ph && !(|data_ph && !last_beat)) |=> (|data_ph));
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|addr_ph && |data_ph && !last_beat) |=> $stable(addr_ph) && $stable(bus_addr));
  assert_no_gnt_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|addr_ph && |data_ph && !last_beat) |-> !(|gnt));
  assert_last_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> (|data_ph));
  assert_phase_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_ph) && $onehot0(data_ph) && $onehot0(err));
  assert_err_no_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|err) |-> !(|addr_ph));
endmodule

// File: tb/shared_bus_ctrl_test.sv
`timescale 1ns/100ps
module shared_bus_ctrl_test;
  localparam int NM = 3, AW = 32;
  logic clk = 0, rst_n = 0;
  logic [NM-1:0] req = '0, wr = '0;
  logic [NM*AW-1:0] addr = '0;
  logic [2*NM-1:0] size = '0, blen = '0;
  logic [NM-1:0] gnt, addr_ph, data_ph, err;
  logic last_beat, bus_wr;
  logic [AW-1:0] bus_addr;

  shared_bus_ctrl #(.NM(NM), .AW(AW)) uut (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    int cyc; logic [NM-1:0] g, a, d, e; logic l;
    logic [AW-1:0] ad; logic w; string tag;
  } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit mon_en = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic ex(int c, logic [NM-1:0] g, a, d, logic l, logic [NM-1:0] e,
                    logic [AW-1:0] ad, logic w, string tag);
    exp_t x;
    x.cyc = c; x.g = g; x.a = a; x.d = d; x.l = l; x.e = e;
    x.ad = ad; x.w = w; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic setm(int i, logic [AW-1:0] a, logic w, logic [1:0] sz, logic [1:0] bl);
    addr[i*AW +: AW] = a; wr[i] = w; size[i*2 +: 2] = sz; blen[i*2 +: 2] = bl;
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) if (mon_en) begin
    exp_t e;
    bit bad;
    if (q.size() > 0 && q[0].cyc == cyc) e = q.pop_front();
    else begin
      e.cyc = cyc; e.g = '0; e.a = '0; e.d = '0; e.l = 0; e.e = '0;
      e.ad = '0; e.w = 0; e.tag = "R1 idle";
    end
    checks++;
    bad = (gnt !== e.g) || (addr_ph !== e.a) || (data_ph !== e.d) ||
          (last_beat !== e.l) || (err !== e.e) ||
          ((e.a != 0) && (bus_addr !== e.ad)) || ((e.d != 0) && (bus_wr !== e.w));
    if (bad) begin
      fails++;
      $display("FAIL %s cyc=%0d actual g=%b a=%b d=%b l=%b e=%b ad=%h w=%b expected g=%b a=%b d=%b l=%b e=%b ad=%h w=%b",
               e.tag, cyc, gnt, addr_ph, data_ph, last_beat, err, bus_addr, bus_wr,
               e.g, e.a, e.d, e.l, e.e, e.ad, e.w);
    end
  end

  initial begin
    int s;
    req = '1;
    step(2);
    checks++;
    if (gnt !== 0 || addr_ph !== 0 || data_ph !== 0 || err !== 0 || last_beat !== 0) begin
      fails++;
      $display("FAIL R11 reset state g=%b a=%b d=%b e=%b l=%b expected all zero",
               gnt, addr_ph, data_ph, err, last_beat);
    end
    req = '0; rst_n = 1; mon_en = 1;
    step(2);

    // R1 R3 R4 R5 R8: single byte at odd address
    s = cyc;
    ex(s, 3'b001, 0, 0, 0, 0, 0, 0, "R1 grant");
    ex(s+1, 0, 3'b001, 0, 0, 0, 32'h13, 0, "R3 addr");
    ex(s+2, 0, 0, 3'b001, 1, 0, 0, 0, "R4 R5 data");
    setm(0, 32'h13, 0, 0, 0); req = 3'b001; step; req = 0; step(4);

    // R2: simultaneous requests
    s = cyc;
    ex(s, 3'b001, 0, 0, 0, 0, 0, 0, "R2 prio");
    ex(s+1, 3'b010, 3'b001, 0, 0, 0, 32'h20, 0, "R2 loser");
    ex(s+2, 0, 3'b010, 3'b001, 1, 0, 32'h24, 1, "R7 overlap");
    ex(s+3, 0, 0, 3'b010, 1, 0, 0, 0, "R4 rd");
    setm(0, 32'h20, 1, 2, 0); setm(1, 32'h24, 0, 2, 0);
    req = 3'b011; step; req = 3'b010; step; req = 0; step(4);

    // R6: block of 4 stalls next address phase and a third grant
    s = cyc;
    ex(s, 3'b001, 0, 0, 0, 0, 0, 0, "R1 blk");
    ex(s+1, 3'b010, 3'b001, 0, 0, 0, 32'h40, 0, "R3 blk");
    for (int k = 2; k < 5; k++) ex(s+k, 0, 3'b010, 3'b001, 0, 0, 32'h100, 1, "R6 stall");
    ex(s+5, 3'b100, 3'b010, 3'b001, 1, 0, 32'h100, 1, "R6 release");
    ex(s+6, 0, 3'b100, 3'b010, 1, 0, 32'h202, 0, "R6 follow");
    ex(s+7, 0, 0, 3'b100, 1, 0, 0, 1, "R4 last");
    setm(0, 32'h40, 1, 3, 1); setm(1, 32'h100, 0, 2, 0); setm(2, 32'h202, 1, 1, 0);
    req = 3'b001; step; req = 3'b110; step; req = 3'b100; step(4); req = 0; step(4);

    // R8 R10: byte fine, word misaligned
    s = cyc;
    ex(s, 3'b001, 0, 0, 0, 0, 0, 0, "R8");
    ex(s+1, 3'b100, 3'b001, 0, 0, 0, 32'h3, 0, "R8 byte");
    ex(s+2, 0, 0, 3'b001, 1, 3'b100, 0, 0, "R10 word err");
    setm(0, 32'h3, 0, 0, 0); setm(2, 32'h2, 0, 2, 0);
    req = 3'b101; step; req = 3'b100; step; req = 0; step(4);

    // R8 R10: half-word misaligned then aligned
    s = cyc;
    ex(s, 3'b010, 0, 0, 0, 0, 0, 0, "R8");
    ex(s+1, 0, 0, 0, 0, 3'b010, 0, 0, "R10 half err");
    setm(1, 32'h5, 0, 1, 0); req = 3'b010; step; req = 0; step(3);
    s = cyc;
    ex(s, 3'b010, 0, 0, 0, 0, 0, 0, "R8");
    ex(s+1, 0, 3'b010, 0, 0, 0, 32'h6, 0, "R8 half ok");
    ex(s+2, 0, 0, 3'b010, 1, 0, 0, 1, "R8 half data");
    setm(1, 32'h6, 1, 1, 0); req = 3'b010; step; req = 0; step(4);

    // R10 R6: misaligned word waiting behind block of 2
    s = cyc;
    ex(s, 3'b001, 0, 0, 0, 0, 0, 0, "R1");
    ex(s+1, 3'b010, 3'b001, 0, 0, 0, 32'h8, 0, "R9 blk2");
    ex(s+2, 0, 0, 3'b001, 0, 0, 0, 1, "R10 stalled err");
    ex(s+3, 0, 0, 3'b001, 1, 3'b010, 0, 1, "R10 delayed err");
    setm(0, 32'h8, 1, 3, 0); setm(1, 32'h1, 0, 2, 0);
    req = 3'b001; step; req = 3'b010; step; req = 0; step(4);

    // R9: block 8 misaligned, block code 3
    s = cyc;
    ex(s, 3'b100, 0, 0, 0, 0, 0, 0, "R9");
    ex(s+1, 0, 0, 0, 0, 3'b100, 0, 0, "R9 blk8 err");
    setm(2, 32'h10, 0, 3, 2); req = 3'b100; step; req = 0; step(3);
    s = cyc;
    ex(s, 3'b010, 0, 0, 0, 0, 0, 0, "R9");
    ex(s+1, 0, 0, 0, 0, 3'b010, 0, 0, "R9 code3 err");
    setm(1, 32'h0, 0, 3, 3); req = 3'b010; step; req = 0; step(3);

    // R5: aligned block of 8
    s = cyc;
    ex(s, 3'b010, 0, 0, 0, 0, 0, 0, "R5");
    ex(s+1, 0, 3'b010, 0, 0, 0, 32'h20, 0, "R5 addr");
    for (int k = 2; k < 9; k++) ex(s+k, 0, 0, 3'b010, 0, 0, 0, 0, "R5 beat");
    ex(s+9, 0, 0, 3'b010, 1, 0, 0, 0, "R5 last8");
    setm(1, 32'h20, 0, 3, 2); req = 3'b010; step; req = 0; step(12);

    // R7: same master back to back
    s = cyc;
    ex(s, 3'b100, 0, 0, 0, 0, 0, 0, "R7");
    ex(s+1, 3'b100, 3'b100, 0, 0, 0, 32'h30, 0, "R7 second");
    ex(s+2, 0, 3'b100, 3'b100, 1, 0, 32'h34, 1, "R7 pipe");
    ex(s+3, 0, 0, 3'b100, 1, 0, 0, 1, "R7 end");
    setm(2, 32'h30, 1, 2, 0); req = 3'b100; step;
    setm(2, 32'h34, 1, 2, 0); step; req = 0; step(4);

    // R11: reset mid block
    s = cyc;
    ex(s, 3'b001, 0, 0, 0, 0, 0, 0, "R11");
    ex(s+1, 0, 3'b001, 0, 0, 0, 32'h0, 0, "R11 addr");
    ex(s+2, 0, 0, 3'b001, 0, 0, 0, 1, "R1 R11 no gnt in reset");
    setm(0, 32'h0, 1, 3, 2); req = 3'b001; step; req = 0; step;
    rst_n = 0; req = 3'b001; step; rst_n = 1; req = 0; step(5);

    mon_en = 0;
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1 leftover expectations actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule